// File: doc/BRIEF.md
# Pseudo-Ternary Frame Line Encoder

This block turns a serial payload stream into pseudo-ternary (inverted-AMI) line symbols for a four-wire basic-rate subscriber interface. Each clock cycle is one bit period. A 48-position frame counter decides what each period carries:
- a forced framing pulse;
- a forced framing balance pulse;
- a payload bit;
- an echo bit;
- a computed d.c.-balance bit.

Each symbol comes out as a registered two-bit code.

A binary one is sent as no pulse. A binary zero is sent as a pulse, and successive zero pulses alternate in polarity. The frame boundary is marked by a deliberate violation: the first zero after the framing balance pulse has the same polarity as that balance pulse.

A direction input selects one of two bit schedules:
- Network-to-terminal: carries echo positions that return the terminal's D-channel bits, and balances the whole frame body with one bit in the final position.
- Terminal-to-network: places a balance bit after every channel group.

The direction is sampled at the first position of each frame and kept for the rest of that frame. The payload source watches a take strobe to learn in which cycles its bit is consumed.

Top module: `ternary_frame_encoder`

## Requirements
- R1: A frame lasts 48 clock cycles. The output `frame_sync` is high in exactly the cycle in which the framing symbol of a frame is on the outputs. That is once every 48 cycles, and first in the second cycle after reset is released.
- R2: The outputs {`sym_p`,`sym_n`} encode a positive pulse as 10, a negative pulse as 01 and no pulse as 00. The code 11 never appears.
- R3: Position 0 of every frame is a positive pulse and position 1 is a negative pulse, whatever the inputs.
- R4: A payload bit of one gives 00. Zero pulses at positions 2 to 47 alternate in polarity, except that the first of them in a frame is negative, the same polarity as position 1.
- R5: In network-to-terminal frames, positions 10, 20, 30 and 40 carry `echo_in` as sampled in that cycle. All other positions from 2 to 46 carry `data_in`.
- R6: In network-to-terminal frames, position 47 is a balance bit. It is zero exactly when positions 2 to 46 hold an odd number of zeros, so that positions 2 to 47 hold an even count.
- R7: In terminal-to-network frames, positions 10, 12, 21, 23, 32, 34, 43, 45 and 47 are balance bits. Each makes even the count of zeros from the position after the previous balance bit (or from position 2) up to and including itself. All other positions from 2 to 46 carry `data_in`.
- R8: `bit_take` is high in exactly the cycles whose position carries `data_in` under the frame's schedule. Its value in a given cycle depends only on the position and the direction.
- R9: `dir_nt` (1 = network-to-terminal) is sampled in the cycle of position 0. Changes at any other position have no effect on the current frame.
- R10: A synchronous reset forces the outputs to 00 with `frame_sync` low, and restarts the frame at position 0 with the polarity tracker cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-period clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_nt | input | 1 | Direction select, 1 = network-to-terminal, sampled at position 0 |
| data_in | input | 1 | Payload bit, consumed when `bit_take` is high |
| echo_in | input | 1 | Echo bit, consumed at echo positions of network-to-terminal frames |
| sym_p | output | 1 | Registered positive-pulse flag |
| sym_n | output | 1 | Registered negative-pulse flag |
| frame_sync | output | 1 | High while the framing symbol is on the outputs |
| bit_take | output | 1 | High when `data_in` is consumed in this cycle |

## Verification
A wrong polarity tracker shows up at the next zero symbol. The bench then sees a pulse of the wrong sign, or a missing frame violation, within one symbol time of the fault.

A wrong parity state appears at the next balance position as a pulse where no pulse was due, or the reverse. That is within 11 cycles in terminal-to-network frames and within one frame in network-to-terminal frames.

A slip of the position counter or of the latched direction corrupts `bit_take` in the same cycle. It also moves `frame_sync` off its 48-cycle spacing by the next frame start. Every symbol is compared against an independent model of the two schedules.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

    localparam int FRAME_LEN  = 48;
    localparam int POS_W      = $clog2(FRAME_LEN);
    localparam int BODY_START = 2;
    localparam int NT_PERIOD  = 20;
    localparam int NT_ECHO_A  = 8;
    localparam int NT_ECHO_B  = 18;
    localparam int NT_BODY    = 40;
    localparam int TE_PERIOD  = 22;
    localparam int TE_BODY    = 44;

    typedef enum logic [2:0] {
        SL_FRAME = 3'd0,
        SL_FBAL  = 3'd1,
        SL_DATA  = 3'd2,
        SL_ECHO  = 3'd3,
        SL_BAL   = 3'd4
    } slot_e;

    typedef struct packed {
        logic p;
        logic n;
    } sym_t;

    localparam sym_t SYM_NONE = '{p: 1'b0, n: 1'b0};
    localparam sym_t SYM_POS  = '{p: 1'b1, n: 1'b0};
    localparam sym_t SYM_NEG  = '{p: 1'b0, n: 1'b1};

    // Kind of bit carried at a frame position for the chosen direction.
    function automatic slot_e slot_kind(input logic [POS_W-1:0] pos, input logic nt);
        int p;
        int rel;
        p = int'(pos);
        if (p == 0)             return SL_FRAME;
        if (p == 1)             return SL_FBAL;
        if (p == FRAME_LEN - 1) return SL_BAL;
        if (nt) begin
            if (p >= BODY_START + NT_BODY) return SL_DATA;
            rel = (p - BODY_START) % NT_PERIOD;
            if (rel == NT_ECHO_A || rel == NT_ECHO_B) return SL_ECHO;
            return SL_DATA;
        end
        if (p >= BODY_START + TE_BODY) return SL_DATA;
        rel = (p - BODY_START) % TE_PERIOD;
        if (rel == 8 || rel == 10 || rel == 19 || rel == 21) return SL_BAL;
        return SL_DATA;
    endfunction

endpackage

// File: rtl/tfe_frame_sched.sv
module tfe_frame_sched
    import tfe_pkg::*;
#(
    parameter int LEN = FRAME_LEN,
    localparam int W  = $clog2(LEN)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  dir_in,
    output slot_e kind,
    output logic  nt_eff
);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;
    logic         dir_q;

    // Position 0 takes the live direction; later positions use the latched copy.
    assign nt_eff = (cnt == '0) ? dir_in : dir_q;
    assign kind   = slot_kind(POS_W'(cnt), nt_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            dir_q <= 1'b0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == '0) dir_q <= dir_in;
        end
    end

    // R1: the position counter wraps to zero after the last position
    a_r1_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> (cnt == '0));

    // R9: the latched direction changes only at a frame start
    a_r9_dir_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> $stable(dir_q));

endmodule

// File: rtl/tfe_dc_balance.sv
module tfe_dc_balance
    import tfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_e kind,
    input  logic  data_in,
    input  logic  echo_in,
    output logic  line_bit
);
    logic odd;

    always_comb begin
        case (kind)
            SL_FRAME, SL_FBAL: line_bit = 1'b0;
            SL_DATA:           line_bit = data_in;
            SL_ECHO:           line_bit = echo_in;
            SL_BAL:            line_bit = ~odd;
            default:           line_bit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            odd <= 1'b0;
        end else begin
            case (kind)
                SL_FRAME, SL_FBAL, SL_BAL: odd <= 1'b0;
                SL_DATA, SL_ECHO:          if (!line_bit) odd <= ~odd;
                default:                   odd <= odd;
            endcase
        end
    end

    // R6/R7: a group closes with an even zero count, so parity is clear after it
    a_r7_group_closed: assert property (@(posedge clk) disable iff (rst)
        (kind == SL_BAL) |=> !odd);

endmodule

// File: rtl/tfe_ami_shaper.sv
module tfe_ami_shaper
    import tfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_e kind,
    input  logic  line_bit,
    output sym_t  sym,
    output logic  fsync
);
    logic next_neg;
    sym_t sym_d;
    sym_t sym_q;
    logic fs_q;

    always_comb begin
        sym_d = SYM_NONE;
        if (!line_bit) begin
            case (kind)
                SL_FRAME: sym_d = SYM_POS;
                SL_FBAL:  sym_d = SYM_NEG;
                default:  sym_d = next_neg ? SYM_NEG : SYM_POS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_neg <= 1'b0;
            sym_q    <= SYM_NONE;
            fs_q     <= 1'b0;
        end else begin
            sym_q <= sym_d;
            fs_q  <= (kind == SL_FRAME);
            if (kind == SL_FBAL)
                next_neg <= 1'b1;
            else if (kind != SL_FRAME && !line_bit)
                next_neg <= ~next_neg;
        end
    end

    assign sym   = sym_q;
    assign fsync = fs_q;

    // R2: both pulse flags are never raised together
    a_r2_no_both: assert property (@(posedge clk) disable iff (rst)
        !(sym_q.p && sym_q.n));

    // R3: the framing symbol is a positive pulse
    a_r3_frame_pos: assert property (@(posedge clk) disable iff (rst)
        fs_q |-> (sym_q == SYM_POS));

    // R3: the symbol after the framing pulse is negative
    a_r3_fbal_neg: assert property (@(posedge clk) disable iff (rst)
        fs_q |=> (sym_q == SYM_NEG));

endmodule

// File: rtl/ternary_frame_encoder.sv
module ternary_frame_encoder
    import tfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dir_nt,
    input  logic data_in,
    input  logic echo_in,
    output logic sym_p,
    output logic sym_n,
    output logic frame_sync,
    output logic bit_take
);
    slot_e kind;
    logic  nt_eff;
    logic  line_bit;
    sym_t  sym;

    tfe_frame_sched #(.LEN(FRAME_LEN)) u_sched (
        .clk    (clk),
        .rst    (rst),
        .dir_in (dir_nt),
        .kind   (kind),
        .nt_eff (nt_eff)
    );

    tfe_dc_balance u_bal (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .data_in  (data_in),
        .echo_in  (echo_in),
        .line_bit (line_bit)
    );

    tfe_ami_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .line_bit (line_bit),
        .sym      (sym),
        .fsync    (frame_sync)
    );

    assign sym_p    = sym.p;
    assign sym_n    = sym.n;
    assign bit_take = (kind == SL_DATA);

    // R5: echo positions exist only in network-to-terminal frames
    a_r5_echo_dir: assert property (@(posedge clk) disable iff (rst)
        (kind == SL_ECHO) |-> nt_eff);

    // R10: the cycle after reset shows no pulse
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!sym_p && !sym_n && !frame_sync));

endmodule

// File: tb/ternary_frame_encoder_test.sv
module ternary_frame_encoder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_nt = 1'b0;
    logic data_in = 1'b1;
    logic echo_in = 1'b1;
    logic sym_p, sym_n, frame_sync, bit_take;

    ternary_frame_encoder uut (
        .clk        (clk),
        .rst        (rst),
        .dir_nt     (dir_nt),
        .data_in    (data_in),
        .echo_in    (echo_in),
        .sym_p      (sym_p),
        .sym_n      (sym_n),
        .frame_sync (frame_sync),
        .bit_take   (bit_take)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    typedef struct {
        int    stamp;
        logic  p;
        logic  n;
        logic  fs;
        string req;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;

    int   mpos = 0;
    logic mdir = 1'b0;
    logic mneg = 1'b0;
    logic modd = 1'b0;
    logic [15:0] lf = 16'hACE1;

    // 0 frame, 1 frame balance, 2 data, 3 echo, 4 balance
    function automatic int tb_kind(input int pos, input logic nt);
        if (pos == 0) return 0;
        if (pos == 1) return 1;
        if (pos == 47) return 4;
        if (nt) begin
            if (pos == 10 || pos == 20 || pos == 30 || pos == 40) return 3;
            return 2;
        end
        if (pos == 10 || pos == 12 || pos == 21 || pos == 23 ||
            pos == 32 || pos == 34 || pos == 43 || pos == 45) return 4;
        return 2;
    endfunction

    function automatic logic rbit();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    task automatic drive(input logic r, input logic d, input logic dd, input logic e);
        int   k;
        logic nt;
        logic b;
        logic ep, en;
        string req;
        @(negedge clk);
        rst = r; dir_nt = d; data_in = dd; echo_in = e;
        if (r) begin
            q.push_back('{cyc, 1'b0, 1'b0, 1'b0, "R10"});
            mpos = 0; mneg = 1'b0; modd = 1'b0;
            return;
        end
        nt = (mpos == 0) ? d : mdir;
        if (mpos == 0) mdir = d;
        k = tb_kind(mpos, nt);
        case (k)
            0, 1:    b = 1'b0;
            2:       b = dd;
            3:       b = e;
            default: b = ~modd;
        endcase
        #1;
        n_cmp++;
        if (bit_take !== (k == 2)) begin
            n_bad++;
            $display("FAIL R8 pos %0d bit_take actual %b expected %b", mpos, bit_take, (k == 2));
        end
        ep = 1'b0; en = 1'b0;
        if (!b) begin
            if (k == 0) ep = 1'b1;
            else if (k == 1) en = 1'b1;
            else begin
                if (mneg) en = 1'b1; else ep = 1'b1;
            end
        end
        if (k == 1) mneg = 1'b1;
        else if (k != 0 && !b) mneg = ~mneg;
        if (k == 0 || k == 1 || k == 4) modd = 1'b0;
        else if (!b) modd = ~modd;
        if (k <= 1)      req = "R3";
        else if (k == 2) req = "R4";
        else if (k == 3) req = "R5";
        else             req = nt ? "R6" : "R7";
        if (mpos != 0 && d != nt) req = {req, "/R9"};
        q.push_back('{cyc, ep, en, (mpos == 0), req});
        mpos = (mpos + 1) % 48;
    endtask

    // pat: 0 random, 1 all ones, 2 all zeros, 3 random with direction changing mid-frame
    task automatic run_frame(input logic dir, input int pat);
        for (int i = 0; i < 48; i++) begin
            logic dd, e, d;
            case (pat)
                1:       begin dd = 1'b1; e = 1'b1; end
                2:       begin dd = 1'b0; e = 1'b0; end
                default: begin dd = rbit(); e = rbit(); end
            endcase
            d = (pat == 3 && i != 0) ? rbit() : dir;
            drive(1'b0, d, dd, e);
        end
    endtask

    // Monitor: pops the item whose symbol is now on the outputs.
    always @(negedge clk) begin
        if (cyc > 1) begin
            n_cmp++;
            if (sym_p === 1'b1 && sym_n === 1'b1) begin
                n_bad++;
                $display("FAIL R2 code actual 11 expected not 11");
            end
        end
        if (q.size() > 0 && q[0].stamp < cyc) begin
            exp_t x;
            x = q.pop_front();
            n_cmp++;
            if (sym_p !== x.p || sym_n !== x.n) begin
                n_bad++;
                $display("FAIL %s symbol actual %b%b expected %b%b", x.req, sym_p, sym_n, x.p, x.n);
            end
            n_cmp++;
            if (frame_sync !== x.fs) begin
                n_bad++;
                $display("FAIL R1 frame_sync actual %b expected %b", frame_sync, x.fs);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(100000 * 4);
        n_bad++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        // R10: reset state
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b1, 1'b1);
        // R5, R6: network-to-terminal frames
        run_frame(1'b1, 0);
        run_frame(1'b1, 0);
        run_frame(1'b1, 1);
        run_frame(1'b1, 2);
        // R7: terminal-to-network frames
        run_frame(1'b0, 0);
        run_frame(1'b0, 0);
        run_frame(1'b0, 2);
        run_frame(1'b0, 1);
        // R9: direction toggled after position 0
        run_frame(1'b1, 3);
        run_frame(1'b0, 3);
        run_frame(1'b1, 0);
        // R10: reset in mid-frame, then restart
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b0, rbit(), rbit());
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        run_frame(1'b1, 0);
        run_frame(1'b0, 0);
        for (int i = 0; i < 30; i++) run_frame(i[0], 0);
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        #2;
        finish_run();
    end

endmodule